// File: doc/BRIEF.md
# Video Crop and Scale Window

This block sits behind a video digitizer that delivers one field at a time. Each input cycle may carry one sample with a valid strobe. One-cycle sync pulses mark the start of a line and the start of a field, and a field flag is latched at each field start. The block discards a programmable number of lines after each field start and a programmable number of samples after each line start. It then keeps a window of programmable height and width. Inside that window it thins the stream to a smaller output size by dropping samples and lines.

The thinning uses two 12-bit scale factors in 8.8 fixed point. A scale of 256 keeps everything. A larger scale keeps roughly 256/scale of the samples. To get a given output width, software writes `active * 256 / width`, and the vertical axis works the same way on lines. The four window values are 10 bits wide and the two scale values are 12 bits wide. Software writes them through a byte-wide port: each value has its own low-byte register, and the upper bits of several values share one packed register. The written settings take effect only at the next field start, so a window change never splits a field.

Kept samples leave one cycle after they arrive, unchanged. Each carries a marker for the first output sample of a line and for the first output sample of a field, along with the field flag of the current field.

Top module: `vid_crop_scale`

## Requirements
- R1: After reset, all outputs are 0. The window in force is: horizontal delay 0, horizontal active 720, vertical delay 24, vertical active 288, both scales 256.
- R2: Sample positions in a line count from 0 at the first valid sample after a line-start pulse. Sample P is a candidate only if hdelay <= P < hdelay + hactive.
- R3: Line positions in a field count from 0 at the first line-start pulse after a field-start pulse. Line L is a candidate only if vdelay <= L < vdelay + vactive. Samples of non-candidate lines are never output.
- R4: Horizontal thinning uses an accumulator that clears at each line start. For each candidate sample it forms s = acc + 256. If s >= hscale, the sample is output and acc becomes s - hscale; otherwise acc becomes s.
- R5: Vertical thinning applies the same rule to candidate lines with vscale. Its accumulator clears at each field start, and a line that is not kept produces no output.
- R6: A scale value below 256, including 0, behaves exactly as 256.
- R7: The register addresses are: 0 hdelay[7:0], 1 hactive[7:0], 2 vdelay[7:0], 3 vactive[7:0], 5 hscale[7:0], 6 vscale[7:0]. Address 4 packs vdelay[9:8] in [7:6], vactive[9:8] in [5:4], hdelay[9:8] in [3:2] and hactive[9:8] in [1:0]. Address 7 packs vscale[11:8] in [7:4] and hscale[11:8] in [3:0].
- R8: A register write has no effect on the current field. It applies from the next field-start pulse. A write in the same cycle as a field-start pulse applies only from the field-start pulse after that.
- R9: out_sol marks the first output sample of each line and out_sof marks the first output sample of each field. out_field equals the flag present at the latest field-start pulse.
- R10: A kept sample appears on out_data with out_valid exactly one cycle after its input cycle. A sample strobed in the same cycle as either sync pulse is ignored and is not counted as a position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Input sample |
| in_hsync | input | 1 | Line-start pulse |
| in_vsync | input | 1 | Field-start pulse |
| in_field | input | 1 | Field flag, latched at field start |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Output sample |
| out_sol | output | 1 | First output sample of a line |
| out_sof | output | 1 | First output sample of a field |
| out_field | output | 1 | Field flag of the current field |

## Verification
Two functions can meet in one cycle: a register write and the field-start pulse that loads the window. The bench provokes this by issuing the write exactly in a field-start cycle. The field that follows is judged against the old settings and the field after it against the new ones. A second overlap is a sample strobed in a sync cycle. Every sync cycle carries a marked junk sample, and the bench requires that this value never reaches the output and that sample positions remain those of the real samples.

// File: rtl/vcs_pkg.sv
// Shared constants and the window type of the crop and scale block.
// Assumes register widths fixed by the byte-wide packing: 10-bit crop
// values and 12-bit scale values.
package vcs_pkg;

    localparam int CROP_W  = 10;
    localparam int SCALE_W = 12;
    localparam int ADDR_W  = 3;
    localparam int UNITY   = 256;

    localparam logic [ADDR_W-1:0] A_HDLY_LO  = 3'd0;
    localparam logic [ADDR_W-1:0] A_HACT_LO  = 3'd1;
    localparam logic [ADDR_W-1:0] A_VDLY_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_VACT_LO  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CROP_HI  = 3'd4;
    localparam logic [ADDR_W-1:0] A_HSCL_LO  = 3'd5;
    localparam logic [ADDR_W-1:0] A_VSCL_LO  = 3'd6;
    localparam logic [ADDR_W-1:0] A_SCALE_HI = 3'd7;

    typedef struct packed {
        logic [CROP_W-1:0]  hdelay;
        logic [CROP_W-1:0]  hactive;
        logic [CROP_W-1:0]  vdelay;
        logic [CROP_W-1:0]  vactive;
        logic [SCALE_W-1:0] hscale;
        logic [SCALE_W-1:0] vscale;
    } vcs_win_t;

    localparam vcs_win_t WIN_RESET = '{
        hdelay:  10'd0,
        hactive: 10'd720,
        vdelay:  10'd24,
        vactive: 10'd288,
        hscale:  12'd256,
        vscale:  12'd256
    };

endpackage

// File: rtl/vcs_regs.sv
// Window register file: byte writes land in a shadow copy, and the shadow
// is copied into the live window on each load pulse (field start).
// Assumes a write and a load in one cycle: the load takes the shadow as it
// was before that write.
module vcs_regs
    import vcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              load,
    output vcs_win_t          win
);

    vcs_win_t shadow;

    // Byte writes into the shadow copy, high bits from packed registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= WIN_RESET;
        end else if (we) begin
            case (addr)
                A_HDLY_LO:  shadow.hdelay[7:0]  <= wdata;
                A_HACT_LO:  shadow.hactive[7:0] <= wdata;
                A_VDLY_LO:  shadow.vdelay[7:0]  <= wdata;
                A_VACT_LO:  shadow.vactive[7:0] <= wdata;
                A_CROP_HI: begin
                    shadow.vdelay[9:8]  <= wdata[7:6];
                    shadow.vactive[9:8] <= wdata[5:4];
                    shadow.hdelay[9:8]  <= wdata[3:2];
                    shadow.hactive[9:8] <= wdata[1:0];
                end
                A_HSCL_LO:  shadow.hscale[7:0]  <= wdata;
                A_VSCL_LO:  shadow.vscale[7:0]  <= wdata;
                A_SCALE_HI: begin
                    shadow.vscale[11:8] <= wdata[7:4];
                    shadow.hscale[11:8] <= wdata[3:0];
                end
                default: ;
            endcase
        end
    end

    // Live window copy, refreshed only at field start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= WIN_RESET;
        end else if (load) begin
            win <= shadow;
        end
    end

    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(win)); // R8

endmodule

// File: rtl/vcs_axis.sv
// One axis of the window: counts positions since restart, tests the crop
// window and runs the drop-based phase accumulator. Used for samples
// (horizontal) and for lines (vertical).
// Assumes restart and step never matter in one cycle (restart wins).
module vcs_axis
    import vcs_pkg::*;
#(
    parameter int CW = CROP_W,
    parameter int SW = SCALE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    input  logic [CW-1:0] delay,
    input  logic [CW-1:0] active,
    input  logic [SW-1:0] scale,
    output logic          keep
);

    localparam int POS_W = CW + 1;
    localparam int ACC_W = SW + 1;
    localparam logic [ACC_W-1:0] ONE = ACC_W'(UNITY);

    logic [POS_W-1:0] pos;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] scale_eff;
    logic [ACC_W-1:0] sum;
    logic [POS_W-1:0] win_end;
    logic             in_win;
    logic             hit;

    // Clamp the scale to unity and evaluate the window and accumulator.
    always_comb begin
        scale_eff = (ACC_W'(scale) < ONE) ? ONE : ACC_W'(scale);
        win_end   = POS_W'(delay) + POS_W'(active);
        in_win    = (pos >= POS_W'(delay)) && (pos < win_end);
        sum       = acc + ONE;
        hit       = sum >= scale_eff;
        keep      = step && in_win && hit;
    end

    // Position counter and phase accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos <= '0;
            acc <= '0;
        end else if (step) begin
            if (pos != '1) begin
                pos <= pos + 1'b1;
            end
            if (in_win) begin
                acc <= hit ? (sum - scale_eff) : sum;
            end
        end
    end

    AST_ACC_BELOW_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        acc < scale_eff); // R4

endmodule

// File: rtl/vid_crop_scale.sv
// Crop and scale window top: a horizontal and a vertical axis engine
// select samples, a shadowed register file supplies the window, and one
// register stage drives the outputs with line and field markers.
// Assumes sync pulses last one cycle; samples in sync cycles are dropped.
module vid_crop_scale
    import vcs_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_hsync,
    input  logic              in_vsync,
    input  logic              in_field,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sol,
    output logic              out_sof,
    output logic              out_field
);

    localparam int N_AXIS = 2;
    localparam int AX_H   = 0;
    localparam int AX_V   = 1;

    vcs_win_t            win;
    logic [CROP_W-1:0]   ax_delay  [N_AXIS];
    logic [CROP_W-1:0]   ax_active [N_AXIS];
    logic [SCALE_W-1:0]  ax_scale  [N_AXIS];
    logic [N_AXIS-1:0]   ax_restart;
    logic [N_AXIS-1:0]   ax_step;
    logic [N_AXIS-1:0]   ax_keep;
    logic                line_on;
    logic                sol_pend;
    logic                sof_pend;
    logic                field_q;

    vcs_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .load  (in_vsync),
        .win   (win)
    );

    assign ax_delay[AX_H]  = win.hdelay;
    assign ax_active[AX_H] = win.hactive;
    assign ax_scale[AX_H]  = win.hscale;
    assign ax_delay[AX_V]  = win.vdelay;
    assign ax_active[AX_V] = win.vactive;
    assign ax_scale[AX_V]  = win.vscale;

    assign ax_restart[AX_H] = in_hsync || in_vsync;
    assign ax_step[AX_H]    = in_valid && !in_hsync && !in_vsync && line_on;
    assign ax_restart[AX_V] = in_vsync;
    assign ax_step[AX_V]    = in_hsync && !in_vsync;

    for (genvar g = 0; g < N_AXIS; g++) begin : g_axis
        vcs_axis #(
            .CW (CROP_W),
            .SW (SCALE_W)
        ) u_axis (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (ax_restart[g]),
            .step    (ax_step[g]),
            .delay   (ax_delay[g]),
            .active  (ax_active[g]),
            .scale   (ax_scale[g]),
            .keep    (ax_keep[g])
        );
    end

    // Line gate: set for a line the vertical engine keeps.
    always_ff @(posedge clk) begin
        if (!rst_n || in_vsync) begin
            line_on <= 1'b0;
        end else if (in_hsync) begin
            line_on <= ax_keep[AX_V];
        end
    end

    // Pending first-of-line and first-of-field markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sol_pend <= 1'b0;
            sof_pend <= 1'b0;
        end else begin
            if (in_hsync || in_vsync) begin
                sol_pend <= 1'b1;
            end else if (ax_keep[AX_H]) begin
                sol_pend <= 1'b0;
            end
            if (in_vsync) begin
                sof_pend <= 1'b1;
            end else if (ax_keep[AX_H]) begin
                sof_pend <= 1'b0;
            end
        end
    end

    // Field flag captured at field start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= 1'b0;
        end else if (in_vsync) begin
            field_q <= in_field;
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sol   <= 1'b0;
            out_sof   <= 1'b0;
        end else begin
            out_valid <= ax_keep[AX_H];
            out_sol   <= ax_keep[AX_H] && sol_pend;
            out_sof   <= ax_keep[AX_H] && sof_pend;
            if (ax_keep[AX_H]) begin
                out_data <= in_data;
            end
        end
    end

    assign out_field = field_q;

    AST_SYNC_DROPS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hsync || in_vsync) |=> !out_valid); // R10
    AST_SOF_IS_SOL: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_sol); // R9
    AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(line_on)); // R3
    AST_MARKER_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sol || out_sof) |-> out_valid); // R9

endmodule

// File: tb/vid_crop_scale_tb.sv
module vid_crop_scale_tb;

    localparam int DW    = 20;
    localparam int MAXE  = 8192;
    localparam logic [DW-1:0] JUNK = 20'hFFFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_hsync = 1'b0;
    logic          in_vsync = 1'b0;
    logic          in_field = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_sol;
    logic          out_sof;
    logic          out_field;

    int checks = 0;
    int errors = 0;

    logic [7:0]    sh [8];
    logic [DW-1:0] exp_d [MAXE];
    logic          exp_l [MAXE];
    logic          exp_f [MAXE];
    int            exp_n;
    logic [DW-1:0] got_d [MAXE];
    logic          got_l [MAXE];
    logic          got_f [MAXE];
    logic          got_fl [MAXE];
    int            got_n = 0;
    int            lat_err = 0;
    logic          cur_fld = 1'b0;

    always #2.5 clk = ~clk;

    vid_crop_scale #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
        .in_hsync(in_hsync), .in_vsync(in_vsync), .in_field(in_field),
        .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol),
        .out_sof(out_sof), .out_field(out_field)
    );

    // Capture outputs shortly after each edge; inputs still hold the
    // values consumed at that edge, so latency is checked here (R10).
    always @(posedge clk) begin
        #1;
        if (rst_n && out_valid) begin
            if (got_n < MAXE) begin
                got_d[got_n]  = out_data;
                got_l[got_n]  = out_sol;
                got_f[got_n]  = out_sof;
                got_fl[got_n] = out_field;
            end
            if (!in_valid || in_hsync || in_vsync || out_data != in_data)
                lat_err++;
            got_n++;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic drv(input logic v, input logic [DW-1:0] d, input logic hs,
                       input logic vs, input logic we, input logic [2:0] a,
                       input logic [7:0] wd);
        in_valid = v; in_data = d; in_hsync = hs; in_vsync = vs;
        in_field = cur_fld; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        @(negedge clk);
        in_valid = 1'b0; in_hsync = 1'b0; in_vsync = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        drv(1'b0, '0, 1'b0, 1'b0, 1'b1, a, d);
        sh[a] = d;
    endtask

    // Program a window with the packing of R7.
    task automatic set_win(input logic [9:0] hd, input logic [9:0] ha,
                           input logic [9:0] vd, input logic [9:0] va,
                           input logic [11:0] hs, input logic [11:0] vs);
        wr(3'd0, hd[7:0]);
        wr(3'd1, ha[7:0]);
        wr(3'd2, vd[7:0]);
        wr(3'd3, va[7:0]);
        wr(3'd4, {vd[9:8], va[9:8], hd[9:8], ha[9:8]});
        wr(3'd5, hs[7:0]);
        wr(3'd6, vs[7:0]);
        wr(3'd7, {vs[11:8], hs[11:8]});
    endtask

    // Drive one field and check it against the model. wpos: -1 no write,
    // -2 write in the field-start cycle, k >= 0 write before line k.
    task automatic run_field(input string tag, input int nlines, input int npix,
                             input int gap, input int wpos,
                             input logic [2:0] wa, input logic [7:0] wd);
        logic [7:0] act [8];
        int hd, ha, vd, va, hs, vs, vacc, hacc, s, p, bad;
        logic lemit, lpend, fpend;
        logic [DW-1:0] d;
        for (int i = 0; i < 8; i++) act[i] = sh[i];
        hd = {act[4][3:2], act[0]};
        ha = {act[4][1:0], act[1]};
        vd = {act[4][7:6], act[2]};
        va = {act[4][5:4], act[3]};
        hs = {act[7][3:0], act[5]};
        vs = {act[7][7:4], act[6]};
        if (hs < 256) hs = 256;
        if (vs < 256) vs = 256;
        cur_fld = ~cur_fld;
        exp_n = 0;
        got_n = 0;
        lat_err = 0;
        drv(1'b1, JUNK, 1'b0, 1'b1, wpos == -2, wa, wd);
        if (wpos == -2) sh[wa] = wd;
        vacc = 0;
        fpend = 1'b1;
        for (int L = 0; L < nlines; L++) begin
            if (wpos == L) wr(wa, wd);
            drv(1'b1, JUNK, 1'b1, 1'b0, 1'b0, 3'd0, 8'd0);
            lemit = 1'b0;
            if (L >= vd && L < vd + va) begin
                s = vacc + 256;
                if (s >= vs) begin lemit = 1'b1; vacc = s - vs; end
                else vacc = s;
            end
            hacc = 0;
            lpend = 1'b1;
            p = 0;
            while (p < npix) begin
                if (int'($urandom_range(99)) < gap) begin
                    drv(1'b0, DW'($urandom), 1'b0, 1'b0, 1'b0, 3'd0, 8'd0);
                end else begin
                    d = {10'(L), 10'(p)};
                    drv(1'b1, d, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0);
                    if (lemit && p >= hd && p < hd + ha) begin
                        s = hacc + 256;
                        if (s >= hs) begin
                            if (exp_n < MAXE) begin
                                exp_d[exp_n] = d;
                                exp_l[exp_n] = lpend;
                                exp_f[exp_n] = fpend;
                            end
                            exp_n++;
                            lpend = 1'b0;
                            fpend = 1'b0;
                            hacc = s - hs;
                        end else begin
                            hacc = s;
                        end
                    end
                    p++;
                end
            end
        end
        repeat (3) drv(1'b0, '0, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0);
        chk(got_n == exp_n, {tag, " R2 R3 output count"}, got_n, exp_n);
        bad = -1;
        for (int i = 0; i < exp_n && i < got_n && i < MAXE; i++)
            if (bad < 0 && got_d[i] != exp_d[i]) bad = i;
        chk(bad < 0, {tag, " R4 R5 kept samples"},
            (bad < 0) ? 0 : int'(got_d[bad]), (bad < 0) ? 0 : int'(exp_d[bad]));
        bad = -1;
        for (int i = 0; i < exp_n && i < got_n && i < MAXE; i++)
            if (bad < 0 && (got_l[i] != exp_l[i] || got_f[i] != exp_f[i])) bad = i;
        chk(bad < 0, {tag, " R9 line/field markers at index"}, bad, -1);
        bad = -1;
        for (int i = 0; i < got_n && i < MAXE; i++)
            if (bad < 0 && got_fl[i] != cur_fld) bad = i;
        chk(bad < 0, {tag, " R9 field flag"}, (bad < 0) ? int'(cur_fld) : int'(got_fl[bad]),
            int'(cur_fld));
        chk(lat_err == 0, {tag, " R10 one-cycle latency"}, lat_err, 0);
        bad = 0;
        for (int i = 0; i < got_n && i < MAXE; i++)
            if (got_d[i] == JUNK) bad++;
        chk(bad == 0, {tag, " R10 sync-cycle sample dropped"}, bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        sh[0] = 8'h00; sh[1] = 8'hD0; sh[2] = 8'h18; sh[3] = 8'h20;
        sh[4] = 8'h12; sh[5] = 8'h00; sh[6] = 8'h00; sh[7] = 8'h11;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_sol && !out_sof && !out_field && out_data == '0,
            "R1 outputs after reset", int'(out_valid), 0);
        // R1: default window, full 720-sample width.
        run_field("R1", 30, 724, 0, -1, 3'd0, 8'd0);
        set_win(10'd5, 10'd40, 10'd3, 10'd10, 12'd256, 12'd256);
        run_field("R2", 12, 60, 25, -1, 3'd0, 8'd0);
        // R8: write mid-field, then in the field-start cycle.
        run_field("R8 mid", 12, 60, 25, 5, 3'd0, 8'd12);
        run_field("R8 next", 12, 60, 25, -1, 3'd0, 8'd0);
        run_field("R8 collide", 12, 60, 25, -2, 3'd0, 8'd20);
        run_field("R8 after", 12, 60, 25, -1, 3'd0, 8'd0);
        set_win(10'd4, 10'd48, 10'd1, 10'd12, 12'd512, 12'd384);
        run_field("R4 R5", 16, 60, 20, -1, 3'd0, 8'd0);
        set_win(10'd2, 10'd30, 10'd0, 10'd6, 12'd100, 12'd0);
        run_field("R6", 8, 40, 20, -1, 3'd0, 8'd0);
        set_win(10'd260, 10'd300, 10'd2, 10'd5, 12'd672, 12'd300);
        run_field("R7 hdelay hi", 10, 600, 10, -1, 3'd0, 8'd0);
        set_win(10'd1, 10'd8, 10'd258, 10'd3, 12'd256, 12'd256);
        run_field("R7 vdelay hi", 262, 10, 0, -1, 3'd0, 8'd0);
        set_win(10'd0, 10'd4, 10'd0, 10'd257, 12'd256, 12'd512);
        run_field("R7 vactive hi", 262, 6, 0, -1, 3'd0, 8'd0);
        for (int k = 0; k < 8; k++) begin
            set_win(10'($urandom_range(40)), 10'($urandom_range(60, 1)),
                    10'($urandom_range(5)), 10'($urandom_range(10, 1)),
                    12'($urandom_range(1000, 200)), 12'($urandom_range(800, 200)));
            run_field("R4 R5 random", 16, 80, 30, -1, 3'd0, 8'd0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule